// File: doc/BRIEF.md
# Rewindable Transmit Byte Queue

This block is a byte-wide first-in first-out queue that sits between a CPU and a serial transmitter. The CPU writes bytes, and the serializer takes them in order while the queue and the transmitter are both enabled. Before a frame starts, with the queue empty, software can mark the current read position. If the frame then fails on the bus, a rewind strobe moves the read position back to that mark, so the same bytes go out again without being written a second time.

Because the storage is a ring, later writes can wrap around and overwrite bytes still covered by the mark. When overrun detection is enabled, the block raises a sticky flag in that case and refuses any rewind until software clears the flag. A data-request flag, gated by an enable, asks the CPU for more bytes whenever the queue runs empty.

Top module: `rtx_fifo`

## Requirements
- R1: A mark strobe records the current read position only when the byte count is zero. A mark strobe while bytes are queued has no effect, so a later rewind still returns to the earlier mark.
- R2: With overrun detection enabled, an accepted write whose slot is the marked slot raises `lost`. This happens when the write position is DEPTH bytes ahead of the mark.
- R3: `lost` is cleared by a queue clear or by an accepted mark. While `lost` is 1, rewind strobes are refused.
- R4: An accepted rewind drives `reloading` high for exactly one cycle. After that cycle the read position equals the mark, and `count` equals the number of bytes written since the mark.
- R5: While `reloading` is 1, every strobe and write except `clr` is ignored. A rewind strobe is refused while `fifo_en` or `tx_busy` is 1.
- R6: `dreq` is 1 whenever `count` is zero and after a clear. It drops when the queue becomes full, or when `dreq_clr` is strobed while `count` is non-zero. A `dreq_clr` strobe while the queue is empty leaves it at 1. `dreq_irq` equals `dreq` AND `dreq_ie`.
- R7: `clr` sets `count` to zero, clears `lost` and cancels a rewind in progress.
- R8: `pop_valid` is 1 exactly when `fifo_en` and `tx_en` are 1, `count` is non-zero and no rewind is in progress. `pop_data` then shows the oldest byte, and `pop_take` consumes it. Bytes leave in write order.
- R9: The depth is a power-of-two parameter, 16 by default. A write while `count` equals DEPTH is dropped.
- R10: After reset, `count` is 0, `dreq` is 1, and `lost`, `reloading` and `pop_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | CPU write strobe |
| wr_data | input | DATA_W | Byte to enqueue |
| pop_take | input | 1 | Serializer consumes the offered byte |
| pop_valid | output | 1 | A byte is offered to the serializer |
| pop_data | output | DATA_W | Oldest queued byte |
| fifo_en | input | 1 | Queue operation enable |
| tx_en | input | 1 | Transmitter enable |
| tx_busy | input | 1 | Transmitter is sending a byte |
| clr | input | 1 | Queue clear strobe |
| save | input | 1 | Mark the read position |
| reload | input | 1 | Rewind the read position to the mark |
| dreq_clr | input | 1 | Clear the data-request flag |
| lost_det_en | input | 1 | Overrun detection enable |
| dreq_ie | input | 1 | Data-request interrupt enable |
| count | output | $clog2(DEPTH)+1 | Number of valid bytes |
| dreq | output | 1 | Data-request flag |
| dreq_irq | output | 1 | Data-request interrupt |
| lost | output | 1 | Marked data overwritten |
| reloading | output | 1 | Rewind in progress |

## Verification
The embedded assertions check several rules on every cycle:
- the mark does not move while bytes are queued;
- a rewind lasts one cycle and lands on the mark;
- writes have no effect during a rewind or when the queue is full;
- refused rewinds never start;
- `dreq` is high whenever the queue is empty;
- a clear always drops `lost`.

Other properties can only be shown by the bench scenarios. These are that the bytes come out in order and repeat in full after a rewind, that an ignored mark leaves the older mark in force, that the overrun flag rises on the exact wrapping write, and that a clear during a rewind leaves the queue empty.

// File: rtl/rtx_pkg.sv
package rtx_pkg;

    // Strobes after qualification, fanned out to the pointer logic and the flags
    typedef struct packed {
        logic wr;
        logic pop;
        logic save;
        logic reload;
        logic clr;
        logic dreq_clr;
    } rtx_acc_t;

    typedef enum logic {
        RL_IDLE = 1'b0,
        RL_BUSY = 1'b1
    } rtx_rl_e;

    function automatic logic is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/rtx_store.sv
module rtx_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/rtx_ptr_ctrl.sv
module rtx_ptr_ctrl
    import rtx_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned P_W  = $clog2(DEPTH) + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  rtx_acc_t       acc,
    input  logic           lost_det_en,
    output logic [P_W-1:0] wr_ptr,
    output logic [P_W-1:0] rd_ptr,
    output logic [P_W-1:0] saved_ptr,
    output logic [P_W-1:0] cnt_nxt,
    output logic           reloading,
    output logic           lost
);

    logic [P_W-1:0] wr_q, rd_q, sv_q;
    logic [P_W-1:0] wr_n, rd_n, sv_n;
    rtx_rl_e        rl_q, rl_n;
    logic           lost_q, lost_n;
    logic           lost_hit;

    // The slot about to be written is the marked slot once the writer is a full ring ahead
    assign lost_hit = acc.wr && lost_det_en && ((wr_q - sv_q) == P_W'(DEPTH));

    always_comb begin
        wr_n   = wr_q;
        rd_n   = rd_q;
        sv_n   = sv_q;
        rl_n   = RL_IDLE;
        lost_n = lost_q;
        if (acc.clr) begin
            wr_n   = '0;
            rd_n   = '0;
            sv_n   = '0;
            lost_n = 1'b0;
        end else begin
            if (acc.wr) begin
                wr_n = wr_q + P_W'(1);
            end
            if (rl_q == RL_BUSY) begin
                rd_n = sv_q;
            end else if (acc.pop) begin
                rd_n = rd_q + P_W'(1);
            end
            if (acc.save) begin
                sv_n   = rd_q;
                lost_n = 1'b0;
            end else if (lost_hit) begin
                lost_n = 1'b1;
            end
            if (acc.reload) begin
                rl_n = RL_BUSY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= '0;
            rd_q   <= '0;
            sv_q   <= '0;
            rl_q   <= RL_IDLE;
            lost_q <= 1'b0;
        end else begin
            wr_q   <= wr_n;
            rd_q   <= rd_n;
            sv_q   <= sv_n;
            rl_q   <= rl_n;
            lost_q <= lost_n;
        end
    end

    assign wr_ptr    = wr_q;
    assign rd_ptr    = rd_q;
    assign saved_ptr = sv_q;
    assign cnt_nxt   = wr_n - rd_n;
    assign reloading = (rl_q == RL_BUSY);
    assign lost      = lost_q;

    AST_RELOAD_LANDS: assert property (@(posedge clk) disable iff (rst)
        (rl_q == RL_BUSY) && !acc.clr |=> (rd_q == $past(sv_q)) && (rl_q == RL_IDLE)); // R4

    AST_LOST_DROPS: assert property (@(posedge clk) disable iff (rst)
        acc.clr |=> !lost_q); // R3

endmodule

// File: rtl/rtx_flags.sv
module rtx_flags
    import rtx_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned P_W  = $clog2(DEPTH) + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  rtx_acc_t       acc,
    input  logic [P_W-1:0] count,
    input  logic [P_W-1:0] cnt_nxt,
    input  logic           dreq_ie,
    output logic           dreq,
    output logic           dreq_irq
);

    logic dreq_q;

    always_ff @(posedge clk) begin
        if (rst || acc.clr) begin
            dreq_q <= 1'b1;
        end else if (cnt_nxt == '0) begin
            dreq_q <= 1'b1;
        end else if (cnt_nxt == P_W'(DEPTH)) begin
            dreq_q <= 1'b0;
        end else if (acc.dreq_clr && (count != '0)) begin
            dreq_q <= 1'b0;
        end
    end

    assign dreq     = dreq_q;
    assign dreq_irq = dreq_q && dreq_ie;

    AST_EMPTY_REQUESTS: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> dreq_q); // R6

endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo
    import rtx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned P_W   = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop_take,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    input  logic              fifo_en,
    input  logic              tx_en,
    input  logic              tx_busy,
    input  logic              clr,
    input  logic              save,
    input  logic              reload,
    input  logic              dreq_clr,
    input  logic              lost_det_en,
    input  logic              dreq_ie,
    output logic [P_W-1:0]    count,
    output logic              dreq,
    output logic              dreq_irq,
    output logic              lost,
    output logic              reloading
);

    logic [P_W-1:0] wr_ptr, rd_ptr, saved_ptr, cnt_nxt;
    logic           full, empty;
    rtx_acc_t       acc;

    assign count = wr_ptr - rd_ptr;
    assign full  = (count == P_W'(DEPTH));
    assign empty = (count == '0);

    assign pop_valid = fifo_en && tx_en && !empty && !reloading;

    always_comb begin
        acc          = '0;
        acc.clr      = clr;
        acc.wr       = wr_valid && !clr && !reloading && !full;
        acc.pop      = pop_valid && pop_take && !clr;
        acc.save     = save && !clr && !reloading && empty;
        acc.reload   = reload && !clr && !reloading && !fifo_en && !tx_busy && !lost;
        acc.dreq_clr = dreq_clr && !clr && !reloading;
    end

    rtx_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .acc         (acc),
        .lost_det_en (lost_det_en),
        .wr_ptr      (wr_ptr),
        .rd_ptr      (rd_ptr),
        .saved_ptr   (saved_ptr),
        .cnt_nxt     (cnt_nxt),
        .reloading   (reloading),
        .lost        (lost)
    );

    rtx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (acc.wr),
        .wr_idx  (wr_ptr[IDX_W-1:0]),
        .wr_data (wr_data),
        .rd_idx  (rd_ptr[IDX_W-1:0]),
        .rd_data (pop_data)
    );

    rtx_flags #(.DEPTH(DEPTH)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .count    (count),
        .cnt_nxt  (cnt_nxt),
        .dreq_ie  (dreq_ie),
        .dreq     (dreq),
        .dreq_irq (dreq_irq)
    );

    initial begin
        assert (is_pow2(DEPTH)) else $error("DEPTH must be a power of two"); // R9
    end

    AST_MARK_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
        save && !clr && !empty |=> $stable(saved_ptr)); // R1

    AST_NO_WRITE_IN_REWIND: assert property (@(posedge clk) disable iff (rst)
        reloading && !clr |=> $stable(wr_ptr)); // R5

    AST_REWIND_REFUSED: assert property (@(posedge clk) disable iff (rst)
        reload && (fifo_en || tx_busy) && !reloading |=> !reloading); // R5

    AST_LOST_BLOCKS_REWIND: assert property (@(posedge clk) disable iff (rst)
        reload && lost && !reloading |=> !reloading); // R3

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
        full && wr_valid && !pop_take && !clr |=> $stable(wr_ptr)); // R9

    AST_REWIND_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        $rose(reloading) |=> !reloading); // R4

endmodule

// File: tb/rtx_fifo_test.sv
`timescale 1ns/1ps
module rtx_fifo_test;

    localparam int DW = 8;
    localparam int DP = 16;
    localparam int PW = $clog2(DP) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 0, pop_take = 0, fifo_en = 0, tx_en = 0, tx_busy = 0;
    logic          clr = 0, save = 0, reload = 0, dreq_clr = 0, lost_det_en = 0, dreq_ie = 0;
    logic [DW-1:0] wr_data = '0;
    logic          pop_valid, dreq, dreq_irq, lost, reloading;
    logic [DW-1:0] pop_data;
    logic [PW-1:0] count;

    int  n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0;
    bit  done = 0;
    logic [DW-1:0] exp_q[$];

    always #4 clk = ~clk;

    rtx_fifo #(.DATA_W(DW), .DEPTH(DP)) uut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .pop_take(pop_take), .pop_valid(pop_valid), .pop_data(pop_data),
        .fifo_en(fifo_en), .tx_en(tx_en), .tx_busy(tx_busy), .clr(clr),
        .save(save), .reload(reload), .dreq_clr(dreq_clr),
        .lost_det_en(lost_det_en), .dreq_ie(dreq_ie), .count(count),
        .dreq(dreq), .dreq_irq(dreq_irq), .lost(lost), .reloading(reloading)
    );

    // Monitor: every byte the serializer takes must match the scoreboard (R8)
    always @(negedge clk) begin
        if (!rst && pop_valid && pop_take) begin
            m_chk++;
            if (exp_q.size() == 0) begin
                m_fail++;
                $display("FAIL R8 unexpected pop: actual %02h expected none", pop_data);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                if (pop_data !== e) begin
                    m_fail++;
                    $display("FAIL R8 pop order: actual %02h expected %02h", pop_data, e);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [DW-1:0] d, input bit expect_out);
        wr_valid = 1; wr_data = d;
        if (expect_out) exp_q.push_back(d);
        tick();
        wr_valid = 0;
    endtask

    task automatic pulse_save();
        save = 1; tick(); save = 0;
    endtask

    task automatic drain();
        fifo_en = 1; tx_en = 1; pop_take = 1;
        for (int i = 0; i < 4 * DP && count != 0; i++) tick();
        pop_take = 0; fifo_en = 0;
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // R10 reset state
        chk(count == 0, "R10 count", count, 0);
        chk(dreq == 1 && lost == 0 && reloading == 0 && pop_valid == 0, "R10 flags",
            {dreq, lost, reloading, pop_valid}, 4'b1000);
        dreq_ie = 1; #1;
        chk(dreq_irq == 1, "R6 irq follows enable", dreq_irq, 1);

        // R6: clearing the request while empty has no effect
        dreq_clr = 1; tick(); dreq_clr = 0;
        chk(dreq == 1, "R6 clear ignored when empty", dreq, 1);

        // R1: mark at empty, then four bytes
        pulse_save();
        for (int i = 0; i < 4; i++) put(8'hA0 + 8'(i), 1);
        chk(count == 4, "R9 count after writes", count, 4);
        dreq_clr = 1; tick(); dreq_clr = 0;
        chk(dreq == 0 && dreq_irq == 0, "R6 clear with data", {dreq, dreq_irq}, 0);

        // R8 gating: transmitter off keeps the byte back
        fifo_en = 1; tx_en = 0; #1;
        chk(pop_valid == 0, "R8 tx disabled", pop_valid, 0);
        tx_en = 1; #1;
        chk(pop_valid == 1, "R8 enabled with data", pop_valid, 1);
        drain();
        chk(count == 0 && dreq == 1, "R6 empty sets request", {count, dreq}, 1);

        // R5: rewind refused while enabled
        fifo_en = 1; reload = 1; tick(); reload = 0; fifo_en = 0;
        chk(reloading == 0, "R5 refused when enabled", reloading, 0);
        tx_busy = 1; reload = 1; tick(); reload = 0; tx_busy = 0;
        chk(reloading == 0, "R5 refused when busy", reloading, 0);

        // R4: rewind, with a write attempted during it (R5)
        reload = 1; tick(); reload = 0;
        chk(reloading == 1, "R4 reloading raised", reloading, 1);
        wr_valid = 1; wr_data = 8'hEE; tick(); wr_valid = 0;
        chk(reloading == 0, "R4 reloading one cycle", reloading, 0);
        chk(count == 4, "R5 write ignored during rewind / R4 count", count, 4);
        for (int i = 0; i < 4; i++) exp_q.push_back(8'hA0 + 8'(i));
        drain();
        chk(exp_q.size() == 0, "R4 resent all bytes", exp_q.size(), 0);

        // R1: mark with data queued is ignored; rewind goes to the older mark
        put(8'hB0, 1); put(8'hB1, 1);
        pulse_save();
        drain();
        reload = 1; tick(); reload = 0; tick();
        chk(count == 6, "R1 ignored mark keeps old mark", count, 6);
        for (int i = 0; i < 4; i++) exp_q.push_back(8'hA0 + 8'(i));
        exp_q.push_back(8'hB0); exp_q.push_back(8'hB1);
        drain();
        chk(exp_q.size() == 0, "R1 replay complete", exp_q.size(), 0);

        // R7: clear during a rewind
        reload = 1; tick(); reload = 0;
        clr = 1; tick(); clr = 0;
        chk(reloading == 0 && count == 0, "R7 clear cancels rewind", count, 0);
        tick();
        chk(count == 0 && dreq == 1, "R7 still empty", count, 0);

        // R2 / R9: fill, overflow drop, then wrap onto the mark
        lost_det_en = 1;
        pulse_save();
        for (int i = 0; i < DP; i++) put(8'h10 + 8'(i), 1);
        chk(count == DP && dreq == 0, "R6 full clears request", count, DP);
        put(8'h77, 0);
        chk(count == DP, "R9 write to full dropped", count, DP);
        fifo_en = 1; tx_en = 1; pop_take = 1; tick(); pop_take = 0; fifo_en = 0;
        chk(lost == 0, "R2 no loss before wrap", lost, 0);
        put(8'h55, 1);
        chk(lost == 1, "R2 overwrite of marked slot", lost, 1);

        // R3: rewind refused while lost, cleared by a new mark
        reload = 1; tick(); reload = 0;
        chk(reloading == 0, "R3 rewind refused when lost", reloading, 0);
        drain();
        chk(exp_q.size() == 0, "R9 data after drop in order", exp_q.size(), 0);
        pulse_save();
        chk(lost == 0, "R3 mark clears lost", lost, 0);

        // R7: clear drops lost flag
        pulse_save();
        for (int i = 0; i < DP; i++) put(8'h30 + 8'(i), 0);
        fifo_en = 1; tx_en = 1; pop_take = 1; exp_q.push_back(8'h30);
        tick(); pop_take = 0; fifo_en = 0;
        put(8'h99, 0);
        chk(lost == 1, "R2 second overwrite", lost, 1);
        clr = 1; tick(); clr = 0;
        chk(lost == 0 && count == 0, "R7 clear drops lost and count", {lost, count}, 0);

        tick();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk + m_chk, n_fail + m_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_chk + m_chk + 1, n_fail + m_fail + 1);
            $finish;
        end
    end

endmodule